// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static RAM holding 256K words of 4 bits. The host presents an address, write data and a read/write flag together with a one-cycle valid strobe. The controller runs one access on the memory pins and then returns a one-cycle done pulse. For a read, the word that was fetched is presented alongside that pulse.

On the memory side the controller drives three active-low strobes: chip select, write enable and output enable. It also drives an 18-bit address and a 4-bit data bus, split into an outgoing value, an incoming value and a drive enable for the pad tristate. Every phase of an access lasts a whole number of clock cycles. These counts are computed at elaboration from the clock period and the selected speed grade. Each count is the nanosecond minimum divided by the period, rounded up, and never less than one cycle. Writes are paced by the write-enable strobe, and output enable stays inactive while they run. Between accesses chip select is raised, which puts the memory in standby.

Top module: `asram_access_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, chip select, write enable and output enable are high, the data drive enable is low and the done pulse is low.
- R2: A read holds chip select low, output enable low and write enable high for RD_LEN cycles. RD_LEN is the largest of ceil(tRC/T), ceil(tAA/T) and ceil(tOE/T), with a minimum of 1. The data bus is sampled on the last of these cycles and returned with done.
- R3: A write has three phases, all with chip select low. First, one cycle with write enable high. Second, WP_LEN cycles with write enable low, where WP_LEN = max(ceil(tWP/T), ceil(tDW/T), 1). Third, REC_LEN cycles with write enable high again, where REC_LEN = max(ceil(tWC/T) - 1 - WP_LEN, 1). The stored word is the one captured at the request.
- R4: Output enable stays high throughout every write.
- R5: The data bus is driven only while write enable is low. After the drive is released, at least one clock passes before output enable can go low.
- R6: The memory address changes only on the clock that accepts a request, while write enable is high. It then holds until the next request is accepted.
- R7: After every access, chip select is high for at least one cycle. Done is a single-cycle pulse and occurs only while chip select is high.
- R8: A request is accepted only when the controller is idle. A valid strobe raised during an access has no effect on the memory.
- R9: The speed grade selects the minimum times used for the phase counts. Grade 0 uses a 12 ns cycle, 12 ns address access, 6 ns output enable access, 10 ns write pulse and 7 ns data setup. Grade 1 uses 15/15/7/12/8 ns and grade 2 uses 20/20/8/15/9 ns. The write cycle minimum equals the read cycle minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Data to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read result, valid with rsp_done |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 4 | Data returned by the memory |

## Verification
Writes and reads use data patterns 0x0, 0xF, 0xA and 0x5, spread over addresses that differ in both the low and the high address bits. This separates stuck or swapped data bits from address bits that are dropped. Per-access strobe counts are compared with phase lengths that the bench derives itself from the 20 ns grade and a 10 ns clock, so an off-by-one in any phase shows up. A write immediately followed by a read of the same address exercises the bus turnaround. A valid strobe held high through a whole write, pointing at a different address, shows whether a busy controller leaks a second access.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_GAP
  } acc_state_e;

  // nanosecond minima per speed grade (R9)
  function automatic int unsigned ns_cycle(input int unsigned grade);
    case (grade)
      0:       return 12;
      1:       return 15;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned ns_oe_access(input int unsigned grade);
    case (grade)
      0:       return 6;
      1:       return 7;
      default: return 8;
    endcase
  endfunction

  function automatic int unsigned ns_we_pulse(input int unsigned grade);
    case (grade)
      0:       return 10;
      1:       return 12;
      default: return 15;
    endcase
  endfunction

  function automatic int unsigned ns_data_setup(input int unsigned grade);
    case (grade)
      0:       return 7;
      1:       return 8;
      default: return 9;
    endcase
  endfunction

  // ceiling division with a floor of one cycle
  function automatic int unsigned to_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // R2: address access equals cycle time in every grade
  function automatic int unsigned rd_len(input int unsigned grade, input int unsigned clk_ns);
    return max2(to_cycles(ns_cycle(grade), clk_ns), to_cycles(ns_oe_access(grade), clk_ns));
  endfunction

  // R3
  function automatic int unsigned wp_len(input int unsigned grade, input int unsigned clk_ns);
    return max2(to_cycles(ns_we_pulse(grade), clk_ns), to_cycles(ns_data_setup(grade), clk_ns));
  endfunction

  function automatic int unsigned rec_len(input int unsigned grade, input int unsigned clk_ns);
    int signed r;
    r = int'(to_cycles(ns_cycle(grade), clk_ns)) - 1 - int'(wp_len(grade, clk_ns));
    return (r < 1) ? 1 : int'(r);
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned RD_LEN  = 2,
  parameter int unsigned WP_LEN  = 2,
  parameter int unsigned REC_LEN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             last,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             done,
  output logic             accept,
  output logic             rd_capture,
  output logic             busy
);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_LEN - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_LEN - 1);

  acc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        load     = 1'b1;
        state_d  = req_write ? ST_WSET : ST_RD;
        load_val = req_write ? '0 : RD_LOAD;
      end
      ST_RD:   if (last) state_d = ST_GAP;
      ST_WSET: if (last) begin
        state_d  = ST_WPUL;
        load     = 1'b1;
        load_val = WP_LOAD;
      end
      ST_WPUL: if (last) begin
        state_d  = ST_WREC;
        load     = 1'b1;
        load_val = REC_LOAD;
      end
      ST_WREC: if (last) state_d = ST_GAP;
      default: state_d = ST_IDLE;
    endcase
  end

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign rd_capture = (state_q == ST_RD) && last;
  assign busy       = (state_q != ST_IDLE);

  // strobes registered from the next state so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n    <= !(state_d inside {ST_RD, ST_WSET, ST_WPUL, ST_WREC});
      we_n    <= (state_d != ST_WPUL);
      oe_n    <= (state_d != ST_RD);
      dq_oe   <= (state_d == ST_WPUL);
      done    <= (state_d == ST_GAP);
    end
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (rd_capture) rsp_rdata <= mem_dq_i;
    end
  end
endmodule

// File: rtl/asram_access_ctrl.sv
module asram_access_ctrl #(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned SPEED_GRADE = 2,
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_LEN  = asram_pkg::rd_len(SPEED_GRADE, CLK_NS);
  localparam int unsigned WP_LEN  = asram_pkg::wp_len(SPEED_GRADE, CLK_NS);
  localparam int unsigned REC_LEN = asram_pkg::rec_len(SPEED_GRADE, CLK_NS);
  localparam int unsigned MAX_LEN = asram_pkg::max2(RD_LEN, asram_pkg::max2(WP_LEN, REC_LEN));
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             accept;
  logic             rd_capture;
  logic             busy;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  asram_seq #(
    .CNT_W   (CNT_W),
    .RD_LEN  (RD_LEN),
    .WP_LEN  (WP_LEN),
    .REC_LEN (REC_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .last       (tmr_last),
    .load       (tmr_load),
    .load_val   (tmr_val),
    .cs_n       (mem_cs_n),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .dq_oe      (mem_dq_oe),
    .done       (rsp_done),
    .accept     (accept),
    .rd_capture (rd_capture),
    .busy       (busy)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_i   (mem_dq_i),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/asram_access_chk.sv
module asram_access_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              busy,
  input logic              rsp_done,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  p_rd_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_oe_off_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_we_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mem_addr));

  p_addr_we_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_we_n);

  p_done_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> mem_cs_n);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (mem_cs_n && !rsp_done));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

bind asram_access_ctrl asram_access_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .busy      (busy),
  .rsp_done  (rsp_done),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/asram_access_ctrl_tb.sv
module asram_access_ctrl_tb;
  localparam int CLK_P = 10;
  // grade 2 minima restated: cycle 20, oe 8, pulse 15, setup 9
  localparam int EXP_RD  = (20 + CLK_P - 1) / CLK_P;
  localparam int EXP_WP  = (15 + CLK_P - 1) / CLK_P;
  localparam int EXP_WC  = (20 + CLK_P - 1) / CLK_P;
  localparam int EXP_REC = (EXP_WC - 1 - EXP_WP < 1) ? 1 : EXP_WC - 1 - EXP_WP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic rsp_done, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  int mon_r5 = 0, mon_r6 = 0, mon_r4 = 0;
  logic [3:0] mem [64];
  logic [17:0] last_wr_addr;
  logic prev_dq_oe = 0, prev_cs_n = 1;
  logic [17:0] prev_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  asram_access_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model, 64 words indexed by the low address bits
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[5:0]] : 4'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
        mem[mem_addr[5:0]] <= mem_dq_o;
        last_wr_addr <= mem_addr;
      end
      if (mem_dq_oe && mem_we_n) mon_r5++;
      if (!mem_oe_n && prev_dq_oe) mon_r5++;
      if (!mem_we_n && !mem_oe_n) mon_r4++;
      if (mem_addr != prev_addr && (!mem_we_n || (!mem_cs_n && !prev_cs_n))) mon_r6++;
      prev_dq_oe = mem_dq_oe;
      prev_cs_n  = mem_cs_n;
      prev_addr  = mem_addr;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [17:0] a, input logic [3:0] d,
                        output logic [3:0] rd, output int oe_lo, output int we_lo,
                        output int cs_lo, output int cs_at_done);
    oe_lo = 0; we_lo = 0; cs_lo = 0; cs_at_done = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 50; i++) begin
      if (rsp_done) break;
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) we_lo++;
      if (!mem_cs_n) cs_lo++;
      @(negedge clk);
    end
    rd = rsp_rdata;
    cs_at_done = mem_cs_n;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 cs_n", mem_cs_n, 1);
    check("R1 we_n", mem_we_n, 1);
    check("R1 oe_n", mem_oe_n, 1);
    check("R1 dq_oe", mem_dq_oe, 0);
    check("R1 done", rsp_done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 cs_n after release", mem_cs_n, 1);
  endtask

  task automatic t_patterns();
    logic [3:0] rd;
    int oe_lo, we_lo, cs_lo, csd;
    logic [3:0] pat [4] = '{4'h0, 4'hF, 4'hA, 4'h5};
    logic [17:0] adr [4] = '{18'h00003, 18'h3FF2C, 18'h20015, 18'h1003E};
    for (int i = 0; i < 4; i++) begin
      access(1, adr[i], pat[i], rd, oe_lo, we_lo, cs_lo, csd);
      check("R3 write address on pins", int'(last_wr_addr), int'(adr[i]));
    end
    for (int i = 0; i < 4; i++) begin
      access(0, adr[i], 4'h0, rd, oe_lo, we_lo, cs_lo, csd);
      check("R2 read data", rd, pat[i]);
    end
  endtask

  task automatic t_timing();
    logic [3:0] rd;
    int oe_lo, we_lo, cs_lo, csd;
    access(1, 18'h00007, 4'h9, rd, oe_lo, we_lo, cs_lo, csd);
    check("R3 write pulse cycles", we_lo, EXP_WP);
    check("R3 write cs low cycles", cs_lo, 1 + EXP_WP + EXP_REC);
    check("R4 oe low during write", oe_lo, 0);
    check("R7 cs high at done (write)", csd, 1);
    access(0, 18'h00007, 4'h0, rd, oe_lo, we_lo, cs_lo, csd);
    check("R2 read oe low cycles", oe_lo, EXP_RD);
    check("R2 read cs low cycles", cs_lo, EXP_RD);
    check("R2 we low during read", we_lo, 0);
    check("R2 read data", rd, 4'h9);
    check("R7 cs high at done (read)", csd, 1);
    @(negedge clk);
    check("R7 done single cycle", rsp_done, 0);
  endtask

  task automatic t_busy_ignore();
    logic [3:0] rd;
    int oe_lo, we_lo, cs_lo, csd;
    access(1, 18'h00011, 4'h6, rd, oe_lo, we_lo, cs_lo, csd);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'h00012; req_wdata = 4'hC;
    @(posedge clk);
    @(negedge clk);
    // hold a different request high for the rest of the access
    req_addr = 18'h00011; req_wdata = 4'h3;
    for (int i = 0; i < 50; i++) begin
      if (rsp_done) break;
      @(negedge clk);
    end
    req_valid = 0;
    access(0, 18'h00011, 4'h0, rd, oe_lo, we_lo, cs_lo, csd);
    check("R8 busy request ignored", rd, 4'h6);
    access(0, 18'h00012, 4'h0, rd, oe_lo, we_lo, cs_lo, csd);
    check("R8 accepted request written", rd, 4'hC);
  endtask

  task automatic t_turnaround();
    logic [3:0] rd;
    int oe_lo, we_lo, cs_lo, csd;
    access(1, 18'h2A02A, 4'hB, rd, oe_lo, we_lo, cs_lo, csd);
    access(0, 18'h2A02A, 4'h0, rd, oe_lo, we_lo, cs_lo, csd);
    check("R5 read after write", rd, 4'hB);
    check("R5 bus drive and turnaround violations", mon_r5, 0);
    check("R4 oe low with we low seen", mon_r4, 0);
    check("R6 address moves outside accept", mon_r6, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    t_reset();
    t_patterns();
    t_timing();
    t_busy_ignore();
    t_turnaround();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule